// File: doc/BRIEF.md
# Self-Test Result Window Checker

This block watches the results of a multi-step self-test conversion run as a converter sequencer hands them over, one result per step. Each result arrives with a valid strobe and a step index. The result of step 0 is held against a fixed window made of a low limit and a high limit. The block keeps the step 0 result as the reference for the run. It judges every later step by how far it sits from that reference: one limit applies above the reference and a second limit applies below it. All values are unsigned.

The block also runs a sequence and timing supervisor. It checks that the steps of a run come in ascending order, from step 1 up to the programmed step count minus one, after a step 0. It also checks that a new run, marked by a step 0, begins within a programmable number of clock cycles.

There are two sticky error flags, one for window violations and one for supervisor violations. Each flag has its own write-one-to-clear pulse. The threshold and limit inputs are meant to come from a register file. That register file should reset each 12-bit threshold to 16.

Top module: `stw_checker`

## Requirements
- R1: While `win_en` is 0, no accepted result sets `err_win`.
- R2: A step 0 result strictly greater than `abs_hi` sets `err_win`. A step 0 result equal to `abs_hi` does not.
- R3: A step 0 result strictly less than `abs_lo` sets `err_win`. A step 0 result equal to `abs_lo` does not.
- R4: For an in-order step k, with 1 <= k < `step_cnt`, `err_win` is set when the result minus the reference is greater than `dev_hi`. Equality passes.
- R5: For an in-order step k, with 1 <= k < `step_cnt`, `err_win` is set when the reference minus the result is greater than `dev_lo`. Equality passes.
- R6: The reference is the most recent step 0 result. It is captured whatever `win_en` is. A nonzero step that is out of order gets no window check.
- R7: While `wdt_en` is 1, `err_wdt` is set if no step 0 arrives within `safe_cycles` cycles of the previous step 0, or of `wdt_en` rising. The timer then starts counting again.
- R8: Every step 0 clears the timer to zero.
- R9: While `wdt_en` is 1, `err_wdt` is set by any nonzero step that is not the next one expected. This covers a nonzero step before any step 0, a skipped step, and a nonzero step after the final step `step_cnt`-1. A step 0 is accepted at any time and begins a new run.
- R10: While `wdt_en` is 0, `err_wdt` is never set.
- R11: Both flags are 0 after reset. A flag rises on the clock edge that accepts the failing strobe, or on the edge where the timeout occurs. It then stays at 1 until its clear input is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| win_en | input | 1 | Enables the window checks |
| wdt_en | input | 1 | Enables the sequence and timing supervisor |
| abs_hi | input | DW | Step 0 upper limit |
| abs_lo | input | DW | Step 0 lower limit |
| dev_hi | input | DW | Allowed rise above the reference |
| dev_lo | input | DW | Allowed fall below the reference |
| step_cnt | input | SW | Number of steps in one run |
| safe_cycles | input | TW | Maximum number of cycles between step 0 results |
| res_vld | input | 1 | Result strobe |
| res_step | input | SW | Step index of the result |
| res_val | input | DW | Result value |
| clr_win | input | 1 | Clears `err_win` |
| clr_wdt | input | 1 | Clears `err_wdt` |
| err_win | output | 1 | Sticky window error |
| err_wdt | output | 1 | Sticky supervisor error |

## Verification
The bench drives results that land exactly on each limit and one code past it. A comparison written as greater-or-equal would fail the equality cases, and one that swapped the two deviation limits would flag the wrong side. It also moves the reference from one run to the next, so a design that kept a stale reference, or that checked stray out-of-order steps, would raise a false window error. For the supervisor, the bench checks a skipped step, a step after the final step, a timeout that is avoided by an early restart, and a timeout that really happens. It also checks that both kinds of error stay silent while their enables are off.

// File: rtl/stw_pkg.sv
package stw_pkg;
  parameter int STW_DW = 12;
  parameter int STW_SW = 4;
  parameter int STW_TW = 16;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_START = 2'd1,
    EV_NEXT  = 2'd2,
    EV_BAD   = 2'd3
  } stw_ev_e;
endpackage

// File: rtl/stw_sticky.sv
module stw_sticky (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  // R11
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/stw_seqwdt.sv
module stw_seqwdt
  import stw_pkg::*;
#(
  parameter int SW = STW_SW,
  parameter int TW = STW_TW
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wdt_en_i,
  input  logic [SW-1:0] step_cnt_i,
  input  logic [TW-1:0] safe_i,
  input  logic          vld_i,
  input  logic [SW-1:0] step_i,
  output logic          start_o,
  output logic          in_order_o,
  output logic          err_o
);
  localparam int EW = SW + 1;

  logic [SW-1:0] exp_q, exp_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] step_inc;
  stw_ev_e       ev;
  logic          tmo;

  assign step_inc = {1'b0, step_i} + EW'(1);

  always_comb begin
    ev = EV_NONE;
    if (vld_i) begin
      if (step_i == '0)
        ev = EV_START;
      else if (step_i == exp_q && step_i < step_cnt_i)
        ev = EV_NEXT;
      else
        ev = EV_BAD;
    end
  end

  always_comb begin
    exp_d = exp_q;
    case (ev)
      EV_START: exp_d = (step_cnt_i <= SW'(1)) ? '0 : SW'(1);
      EV_NEXT:  exp_d = (step_inc == {1'b0, step_cnt_i}) ? '0 : step_inc[SW-1:0];
      default:  exp_d = exp_q;
    endcase
  end

  assign tmo = wdt_en_i && (ev != EV_START) && (cnt_q == safe_i);

  always_comb begin
    if (!wdt_en_i || ev == EV_START || tmo) cnt_d = '0;
    else                                    cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      cnt_q <= '0;
    end else begin
      exp_q <= exp_d;
      cnt_q <= cnt_d;
    end
  end

  assign start_o    = (ev == EV_START);
  assign in_order_o = (ev == EV_NEXT);
  assign err_o      = wdt_en_i && ((ev == EV_BAD) || tmo);

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (vld_i && step_i == '0) |=> (cnt_q == '0));
  // R9
  last_step_wraps_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ev == EV_NEXT && step_inc == {1'b0, step_cnt_i}) |=> (exp_q == '0));
  // R10
  wdt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !wdt_en_i |-> !err_o);
endmodule

// File: rtl/stw_thresh.sv
module stw_thresh
  import stw_pkg::*;
#(
  parameter int DW = STW_DW
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          in_order_i,
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] abs_hi_i,
  input  logic [DW-1:0] abs_lo_i,
  input  logic [DW-1:0] dev_hi_i,
  input  logic [DW-1:0] dev_lo_i,
  output logic          err_o
);
  logic [DW-1:0] ref_q, ref_d;
  logic [DW-1:0] rise, fall;
  logic          abs_bad, rel_bad;

  assign ref_d = start_i ? val_i : ref_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= ref_d;
  end

  always_comb begin
    rise = '0;
    fall = '0;
    if (val_i > ref_q) rise = val_i - ref_q;
    else               fall = ref_q - val_i;
  end

  assign abs_bad = (val_i > abs_hi_i) || (val_i < abs_lo_i);
  assign rel_bad = (rise > dev_hi_i) || (fall > dev_lo_i);

  assign err_o = en_i && ((start_i && abs_bad) || (in_order_i && rel_bad));

  // R1
  win_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |-> !err_o);
  // R6
  ref_capture_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    start_i |=> (ref_q == $past(val_i)));
endmodule

// File: rtl/stw_checker.sv
module stw_checker
  import stw_pkg::*;
#(
  parameter int DW = STW_DW,
  parameter int SW = STW_SW,
  parameter int TW = STW_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_en,
  input  logic          wdt_en,
  input  logic [DW-1:0] abs_hi,
  input  logic [DW-1:0] abs_lo,
  input  logic [DW-1:0] dev_hi,
  input  logic [DW-1:0] dev_lo,
  input  logic [SW-1:0] step_cnt,
  input  logic [TW-1:0] safe_cycles,
  input  logic          res_vld,
  input  logic [SW-1:0] res_step,
  input  logic [DW-1:0] res_val,
  input  logic          clr_win,
  input  logic          clr_wdt,
  output logic          err_win,
  output logic          err_wdt
);
  logic [1:0] rst_sync_q;
  logic       rst_l;
  logic       start, in_order;
  logic       win_hit, wdt_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  stw_seqwdt #(.SW(SW), .TW(TW)) u_seq (
    .clk(clk), .rst_ni(rst_l), .wdt_en_i(wdt_en), .step_cnt_i(step_cnt),
    .safe_i(safe_cycles), .vld_i(res_vld), .step_i(res_step),
    .start_o(start), .in_order_o(in_order), .err_o(wdt_hit)
  );

  stw_thresh #(.DW(DW)) u_thr (
    .clk(clk), .rst_ni(rst_l), .en_i(win_en), .start_i(start),
    .in_order_i(in_order), .val_i(res_val), .abs_hi_i(abs_hi),
    .abs_lo_i(abs_lo), .dev_hi_i(dev_hi), .dev_lo_i(dev_lo), .err_o(win_hit)
  );

  stw_sticky u_flag_win (
    .clk(clk), .rst_ni(rst_l), .set_i(win_hit), .clr_i(clr_win), .flag_o(err_win)
  );

  stw_sticky u_flag_wdt (
    .clk(clk), .rst_ni(rst_l), .set_i(wdt_hit), .clr_i(clr_wdt), .flag_o(err_wdt)
  );

  // R1
  no_win_err_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (!win_en && !err_win) |=> !err_win);
  // R10
  no_wdt_err_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (!wdt_en && !err_wdt) |=> !err_wdt);
endmodule

// File: tb/stw_checker_bench.sv
module stw_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int SW = 4;
  localparam int TW = 16;
  localparam int NVEC = 18;
  localparam int VW = SW + DW + 1;

  // each entry: {step, value, expected err_win}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {4'd0, 12'h600, 1'b0}, {4'd1, 12'h620, 1'b0}, {4'd2, 12'h621, 1'b1},
    {4'd3, 12'h5F0, 1'b0}, {4'd0, 12'h800, 1'b0}, {4'd1, 12'h7EF, 1'b1},
    {4'd2, 12'h800, 1'b0}, {4'd3, 12'h820, 1'b0}, {4'd0, 12'h801, 1'b1},
    {4'd1, 12'h801, 1'b0}, {4'd2, 12'h7F1, 1'b0}, {4'd3, 12'h822, 1'b1},
    {4'd0, 12'h400, 1'b0}, {4'd1, 12'h410, 1'b0}, {4'd2, 12'h3F0, 1'b0},
    {4'd3, 12'h3EF, 1'b1}, {4'd0, 12'h3FF, 1'b1}, {4'd1, 12'h41F, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic win_en, wdt_en;
  logic [DW-1:0] abs_hi, abs_lo, dev_hi, dev_lo;
  logic [SW-1:0] step_cnt;
  logic [TW-1:0] safe_cycles;
  logic res_vld;
  logic [SW-1:0] res_step;
  logic [DW-1:0] res_val;
  logic clr_win, clr_wdt;
  logic err_win, err_wdt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stw_checker u_stw_checker (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .wdt_en(wdt_en),
    .abs_hi(abs_hi), .abs_lo(abs_lo), .dev_hi(dev_hi), .dev_lo(dev_lo),
    .step_cnt(step_cnt), .safe_cycles(safe_cycles), .res_vld(res_vld),
    .res_step(res_step), .res_val(res_val), .clr_win(clr_win),
    .clr_wdt(clr_wdt), .err_win(err_win), .err_wdt(err_wdt)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic send(input logic [SW-1:0] s, input logic [DW-1:0] v);
    @(negedge clk);
    res_vld = 1'b1; res_step = s; res_val = v;
    @(posedge clk);
    @(negedge clk);
    res_vld = 1'b0;
  endtask

  task automatic clear_all();
    clr_win = 1'b1; clr_wdt = 1'b1;
    @(negedge clk);
    clr_win = 1'b0; clr_wdt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; win_en = 1'b1; wdt_en = 1'b0;
    abs_hi = 12'h800; abs_lo = 12'h400; dev_hi = 12'h020; dev_lo = 12'h010;
    step_cnt = 4'd4; safe_cycles = 16'd1000;
    res_vld = 1'b0; res_step = '0; res_val = '0; clr_win = 1'b0; clr_wdt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 reset err_win", err_win, 1'b0);
    check("R11 reset err_wdt", err_wdt, 1'b0);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][VW-1 -: SW], VEC[i][DW:1]);
      check($sformatf("R2-5 vector %0d", i), err_win, VEC[i][0]);
      clear_all();
    end

    // R11 stickiness
    send(4'd0, 12'h900);
    repeat (5) @(negedge clk);
    check("R11 flag held", err_win, 1'b1);
    clear_all();
    check("R11 flag cleared", err_win, 1'b0);

    // R1 window checks off
    win_en = 1'b0;
    send(4'd0, 12'hFFF);
    send(4'd1, 12'h000);
    check("R1 disabled window", err_win, 1'b0);
    win_en = 1'b1;

    // R6 reference moves; stray step not window-checked
    send(4'd0, 12'h500);
    send(4'd2, 12'hF00);
    check("R6 stray step unchecked", err_win, 1'b0);
    send(4'd1, 12'h505);
    check("R6 new reference used", err_win, 1'b0);

    // R10 supervisor off: out-of-order step
    send(4'd3, 12'h500);
    check("R10 disabled supervisor", err_wdt, 1'b0);

    // R9 ordering
    wdt_en = 1'b1;
    send(4'd0, 12'h500);
    send(4'd2, 12'h500);
    check("R9 skipped step", err_wdt, 1'b1);
    clear_all();
    send(4'd1, 12'h500);
    send(4'd2, 12'h500);
    send(4'd3, 12'h500);
    check("R9 in-order steps", err_wdt, 1'b0);
    send(4'd1, 12'h500);
    check("R9 step after final", err_wdt, 1'b1);
    clear_all();
    check("R9 err cleared", err_wdt, 1'b0);

    // R7 R8 timeout
    wdt_en = 1'b0; safe_cycles = 16'd20;
    @(negedge clk);
    wdt_en = 1'b1;
    send(4'd0, 12'h500);
    repeat (15) @(negedge clk);
    check("R7 within safe time", err_wdt, 1'b0);
    send(4'd0, 12'h500);
    repeat (15) @(negedge clk);
    check("R8 restart clears timer", err_wdt, 1'b0);
    repeat (10) @(negedge clk);
    check("R7 timeout", err_wdt, 1'b1);
    wdt_en = 1'b0;
    clear_all();
    repeat (60) @(negedge clk);
    check("R10 no timeout when off", err_wdt, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule